// File: doc/BRIEF.md
# Smartcard Character Framer with Bit Convention Select

This block turns bytes into smartcard characters on a single line and turns characters seen on a line back into bytes. One character takes one baud tick per bit: a start bit, eight data bits, a parity bit and two guard bit times. The baud tick is supplied from outside as a one-cycle strobe. The block does no oversampling, no error signalling on the line and no retransmission.

Two static controls set the bit convention. `msb_first_i` picks the order of the data bits on the line. `data_inv_i` picks the logic polarity of the data and parity bits. With both controls low, the block uses the direct convention. With both controls high, it uses the inverse convention. Parity is even over the logical data in every mode. The start level and the guard level never change with the inversion setting.

The transmit side takes a byte through a valid/ready handshake. The receive side hands out each decoded byte with a one-cycle valid strobe and a parity-error flag. In the system, `line_o` drives an open-drain pad and `line_i` comes back from the wired line.

Top module: `sc_char_framer`

## Requirements
- R1: After reset, `tx_ready_o` is 1, `line_o` is high and `rx_valid_o` is 0. While `tx_ready_o` is 1, `line_o` stays high.
- R2: In every mode, the first bit time of a character (line bit 0) is low, and line bits 10 and 11 are high.
- R3: With `msb_first_i`=0 and `data_inv_i`=0 (direct), line bit 1+j carries data bit j, and a high level means logic 1.
- R4: With `msb_first_i`=1 and `data_inv_i`=1 (inverse), line bit 1+j carries data bit 7-j, and a high level means logic 0. The parity bit is inverted on the line together with the data.
- R5: The logical parity bit, sent as line bit 9, equals the XOR of the eight data bits, which makes parity even. This holds in all four settings of the two controls.
- R6: A byte is accepted in a cycle where `tx_valid_i` and `tx_ready_o` are both 1. `tx_ready_o` falls in the next cycle. It stays low through 12 bit times and returns high on the 13th baud tick after acceptance. `tx_valid_i` has no effect while `tx_ready_o` is 0.
- R7: `line_o` changes only in the cycle after a cycle with `baud_tick_i`=1. Line bit 0 is driven on the first tick after acceptance.
- R8: The receiver samples `line_i` once per baud tick. A low sample while it is idle marks a start bit. The next eight samples are data and the sample after them is parity. The receiver then undoes the polarity and the order set by the same controls and raises `rx_valid_o` for exactly one cycle with the byte on `rx_data_o`.
- R9: `rx_parity_err_o` is 1, together with `rx_valid_o`, when the received parity bit, after the polarity is undone, differs from the XOR of the decoded data. It is 0 otherwise.
- R10: While `line_i` stays high, the receiver delivers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle strobe, one per bit time |
| msb_first_i | input | 1 | 1: MSB first on the line |
| data_inv_i | input | 1 | 1: data and parity inverted on the line |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte offered |
| tx_ready_o | output | 1 | Transmitter can accept a byte |
| line_o | output | 1 | Transmit line level |
| line_i | input | 1 | Receive line level |
| rx_data_o | output | 8 | Decoded byte |
| rx_valid_o | output | 1 | One-cycle strobe for a decoded byte |
| rx_parity_err_o | output | 1 | Parity mismatch on the decoded byte |

## Verification
The hardest case to reach is a character whose parity bit disagrees with its data. A correct transmitter never produces one, so a plain loopback cannot show the error path. To reach it, the bench switches the receive line from the loopback to a bench-driven level and sends frames it builds itself. Some of these frames have the parity bit flipped, and they are sent under all four settings of the two controls. The bench then checks that the byte is still decoded correctly and that the flag is raised. In the same way, the bench holds a long idle high level on the line to show that nothing is received. It also offers a byte while the transmitter is busy to show that the offer is ignored.

// File: rtl/sc_framer_pkg.sv
`timescale 1ns/1ps
package sc_framer_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_DATA = 2'd1,
    RX_PAR  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/sc_conv_map.sv
`timescale 1ns/1ps
// Convention mapping: optional bit reversal, then optional inversion.
// Self-inverse, so it serves both encode and decode.
module sc_conv_map #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] bits_i,
  input  logic              msb_first_i,
  input  logic              inv_i,
  output logic [DATA_W-1:0] bits_o
);
  logic [DATA_W-1:0] rev;

  for (genvar g = 0; g < DATA_W; g++) begin : g_rev
    assign rev[g] = bits_i[DATA_W-1-g];
  end

  always_comb begin
    bits_o = msb_first_i ? rev : bits_i;
    bits_o = bits_o ^ {DATA_W{inv_i}};
  end
endmodule

// File: rtl/sc_tx.sv
`timescale 1ns/1ps
module sc_tx #(
  parameter int DATA_W     = 8,
  parameter int GUARD_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              msb_first_i,
  input  logic              inv_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              line_o
);
  localparam int FRAME_BITS = 1 + DATA_W + 1 + GUARD_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic [DATA_W-1:0]     line_data;
  logic                  par_line;
  logic [FRAME_BITS-1:0] frame_d, frame_q;
  logic [CNT_W-1:0]      cnt_q;

  sc_conv_map #(.DATA_W(DATA_W)) u_map (
    .bits_i      (data_i),
    .msb_first_i (msb_first_i),
    .inv_i       (inv_i),
    .bits_o      (line_data)
  );

  assign par_line = (^data_i) ^ inv_i;
  assign frame_d  = {{GUARD_BITS{1'b1}}, par_line, line_data, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o <= 1'b1;
      line_o  <= 1'b1;
      frame_q <= '1;
      cnt_q   <= '0;
    end else if (ready_o) begin
      if (valid_i) begin
        frame_q <= frame_d;
        cnt_q   <= '0;
        ready_o <= 1'b0;
      end
    end else if (tick_i) begin
      if (cnt_q == CNT_W'(FRAME_BITS)) begin
        ready_o <= 1'b1;
      end else begin
        line_o  <= frame_q[0];
        frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sc_rx.sv
`timescale 1ns/1ps
module sc_rx
  import sc_framer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              msb_first_i,
  input  logic              inv_i,
  input  logic              line_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o
);
  localparam int CNT_W = $clog2(DATA_W);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] dec;

  sc_conv_map #(.DATA_W(DATA_W)) u_map (
    .bits_i      (sh_q),
    .msb_first_i (msb_first_i),
    .inv_i       (inv_i),
    .bits_o      (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      par_err_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          RX_IDLE: if (!line_i) begin
            state_q <= RX_DATA;
            cnt_q   <= '0;
          end
          RX_DATA: begin
            // first line bit ends up in sh_q[0]
            sh_q  <= {line_i, sh_q[DATA_W-1:1]};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DATA_W - 1)) state_q <= RX_PAR;
          end
          RX_PAR: begin
            data_o    <= dec;
            par_err_o <= (^dec) ^ (line_i ^ inv_i);
            valid_o   <= 1'b1;
            state_q   <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sc_char_framer.sv
`timescale 1ns/1ps
module sc_char_framer #(
  parameter int DATA_W     = 8,
  parameter int GUARD_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              msb_first_i,
  input  logic              data_inv_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              line_o,
  input  logic              line_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_parity_err_o
);
  sc_tx #(.DATA_W(DATA_W), .GUARD_BITS(GUARD_BITS)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (baud_tick_i),
    .msb_first_i (msb_first_i),
    .inv_i       (data_inv_i),
    .data_i      (tx_data_i),
    .valid_i     (tx_valid_i),
    .ready_o     (tx_ready_o),
    .line_o      (line_o)
  );

  sc_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (baud_tick_i),
    .msb_first_i (msb_first_i),
    .inv_i       (data_inv_i),
    .line_i      (line_i),
    .data_o      (rx_data_o),
    .valid_o     (rx_valid_o),
    .par_err_o   (rx_parity_err_o)
  );
endmodule

// File: rtl/sc_char_framer_checker.sv
`timescale 1ns/1ps
module sc_char_framer_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic baud_tick_i,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic line_o,
  input logic rx_valid_o
);
  assert_idle_line_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> line_o);

  assert_accept_drops_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  assert_ready_rises_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_ready_o && !baud_tick_i) |=> !tx_ready_o);

  assert_line_moves_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !baud_tick_i |=> $stable(line_o));

  assert_rx_valid_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

bind sc_char_framer sc_char_framer_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .baud_tick_i (baud_tick_i),
  .tx_valid_i  (tx_valid_i),
  .tx_ready_o  (tx_ready_o),
  .line_o      (line_o),
  .rx_valid_o  (rx_valid_o)
);

// File: tb/tb_sc_char_framer.sv
`timescale 1ns/1ps
module tb_sc_char_framer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       baud_tick_i = 1'b0;
  logic       msb_first_i = 1'b0;
  logic       data_inv_i = 1'b0;
  logic [7:0] tx_data_i = 8'h00;
  logic       tx_valid_i = 1'b0;
  logic       tx_ready_o, line_o, rx_valid_o, rx_parity_err_o;
  logic [7:0] rx_data_o;
  logic       inj_en = 1'b0;
  logic       inj_lvl = 1'b1;
  logic       line_i;

  int errors = 0;
  int checks = 0;
  int rx_cnt = 0;
  logic [7:0] rx_last_data;
  logic       rx_last_err;
  bit         done = 0;

  assign line_i = inj_en ? inj_lvl : line_o;

  always #2 clk_i = ~clk_i;

  sc_char_framer dut (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .baud_tick_i     (baud_tick_i),
    .msb_first_i     (msb_first_i),
    .data_inv_i      (data_inv_i),
    .tx_data_i       (tx_data_i),
    .tx_valid_i      (tx_valid_i),
    .tx_ready_o      (tx_ready_o),
    .line_o          (line_o),
    .line_i          (line_i),
    .rx_data_o       (rx_data_o),
    .rx_valid_o      (rx_valid_o),
    .rx_parity_err_o (rx_parity_err_o)
  );

  always @(posedge clk_i) begin
    if (rx_valid_o) begin
      rx_cnt       <= rx_cnt + 1;
      rx_last_data <= rx_data_o;
      rx_last_err  <= rx_parity_err_o;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic msb, input logic inv);
    logic [11:0] f;
    f[0] = 1'b0;
    for (int j = 0; j < 8; j++) f[1+j] = (msb ? d[7-j] : d[j]) ^ inv;
    f[9]  = (^d) ^ inv;
    f[10] = 1'b1;
    f[11] = 1'b1;
    return f;
  endfunction

  // one tick, returns the line level after the tick edge and flags any change between ticks
  task automatic tick_once(output logic lvl, output logic moved);
    @(negedge clk_i) baud_tick_i = 1'b1;
    @(negedge clk_i) baud_tick_i = 1'b0;
    lvl = line_o;
    @(negedge clk_i);
    @(negedge clk_i);
    moved = (line_o !== lvl);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic msb, input logic inv, input bit poke_busy);
    logic [11:0] got, exp;
    logic lvl, moved, any_moved, ready_seen;
    int rx_before;
    string tag;
    tag = (!msb && !inv) ? "R3" : ((msb && inv) ? "R4" : "R5");
    rx_before = rx_cnt;
    exp = exp_frame(d, msb, inv);
    @(negedge clk_i);
    msb_first_i = msb; data_inv_i = inv;
    tx_data_i = d; tx_valid_i = 1'b1;
    @(negedge clk_i);
    tx_valid_i = 1'b0;
    check("R6 ready low after accept", tx_ready_o, 1'b0);
    any_moved = 1'b0; ready_seen = 1'b0;
    for (int k = 0; k < 12; k++) begin
      if (poke_busy && k == 4) begin
        tx_data_i = ~d; tx_valid_i = 1'b1;
        @(negedge clk_i) tx_valid_i = 1'b0;
      end
      tick_once(lvl, moved);
      got[k] = lvl;
      any_moved |= moved;
      ready_seen |= tx_ready_o;
    end
    check("R6 ready low over 12 bits", ready_seen, 1'b0);
    check("R7 line steady between ticks", any_moved, 1'b0);
    check("R2 start/guard", {got[11:10], got[0]}, 3'b110);
    check({tag, " data bits"}, got[8:1], exp[8:1]);
    check("R5 parity bit", got[9], exp[9]);
    tick_once(lvl, moved);
    check("R6 ready back on 13th tick", tx_ready_o, 1'b1);
    check("R8 one byte received", rx_cnt - rx_before, 1);
    check("R8 loopback data", rx_last_data, d);
    check("R9 no error on good frame", rx_last_err, 1'b0);
    if (poke_busy) begin
      for (int k = 0; k < 4; k++) tick_once(lvl, moved);
      check("R6 busy offer ignored, line idle", line_o, 1'b1);
      check("R6 busy offer ignored, ready", tx_ready_o, 1'b1);
      check("R6 busy offer ignored, no extra byte", rx_cnt - rx_before, 1);
    end
  endtask

  task automatic inject(input logic [7:0] d, input logic msb, input logic inv, input bit bad);
    logic [11:0] f;
    logic lvl, moved;
    int rx_before;
    rx_before = rx_cnt;
    f = exp_frame(d, msb, inv);
    if (bad) f[9] = ~f[9];
    @(negedge clk_i);
    msb_first_i = msb; data_inv_i = inv; inj_en = 1'b1;
    for (int k = 0; k < 12; k++) begin
      inj_lvl = f[k];
      tick_once(lvl, moved);
    end
    inj_lvl = 1'b1;
    check("R8 injected byte received", rx_cnt - rx_before, 1);
    check("R8 injected data", rx_last_data, d);
    check("R9 parity flag", rx_last_err, bad);
    inj_en = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic lvl, moved;
    int rx_before;
    void'($urandom(32'h5c17));
    repeat (3) @(negedge clk_i);
    check("R1 reset ready", tx_ready_o, 1'b1);
    check("R1 reset line", line_o, 1'b1);
    check("R1 reset rx_valid", rx_valid_o, 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // directed conventions
    send_frame(8'h01, 1'b0, 1'b0, 0);
    send_frame(8'h01, 1'b1, 1'b1, 0);
    send_frame(8'hA5, 1'b0, 1'b0, 0);
    send_frame(8'hC3, 1'b1, 1'b1, 0);
    send_frame(8'h00, 1'b1, 1'b1, 0);
    send_frame(8'hFF, 1'b0, 1'b0, 0);
    send_frame(8'h3C, 1'b0, 1'b0, 1);

    // R10: long idle high line
    rx_before = rx_cnt;
    inj_en = 1'b1; inj_lvl = 1'b1;
    for (int k = 0; k < 30; k++) tick_once(lvl, moved);
    check("R10 idle line yields nothing", rx_cnt - rx_before, 0);
    inj_en = 1'b0;

    // random frames across all control settings
    for (int n = 0; n < 24; n++) begin
      logic [7:0] d;
      logic [1:0] m;
      d = 8'($urandom);
      m = 2'($urandom);
      send_frame(d, m[1], m[0], (n % 8) == 7);
    end

    // injected frames, good and bad parity, all settings
    for (int m = 0; m < 4; m++) begin
      inject(8'($urandom), m[1], m[0], 1'b0);
      inject(8'($urandom), m[1], m[0], 1'b1);
    end
    inject(8'h00, 1'b0, 1'b0, 1'b1);
    inject(8'hFF, 1'b1, 1'b1, 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule